// File: doc/BRIEF.md
# Reconfigurable Reference Frame Code Generator

This control block turns a compact search configuration into per-slot reference frame codes for a motion estimator. The estimator searches up to four reference frames in parallel. Two configuration values set the search. The first is the signed offset of the oldest past frame to search. The second is the number of frames to search.

From these two values the block produces one signed code and one enable for each of four slots. Codes start at the oldest offset and count upward one step per slot. They pass over offset zero, because zero is the current frame and is never a reference. Slots beyond the requested count carry code zero and a low enable. This lets the downstream comparator reject those slots, and lets the window memories of those slots stay idle.

The configuration is captured only when a group-start pulse marks the beginning of a new group of four macroblocks. The outputs then stay fixed for the whole group search.

Top module: `rfc_code_gen`

## Requirements
- R1: While reset is asserted and after reset until the first group-start pulse, every code is 0 and every enable is low.
- R2: The configuration inputs are sampled only on a rising clock edge where grp_start_i is high, and the outputs change at that edge. At any other edge, changes on the inputs leave the codes and enables unchanged.
- R3: For a starting offset in -4..-1, slot 0 carries a code equal to that offset.
- R4: Each enabled slot after slot 0 carries the code of the previous slot plus one, except that the value 0 is skipped. For example, offset -3 with count 4 gives -3,-2,-1,+1, and offset -2 with count 4 gives -2,-1,+1,+2.
- R5: With a count n in 1..4, exactly slots 0..n-1 are enabled.
- R6: Every slot that is not enabled carries code 0.
- R7: A count of 0 is treated as 1, and a count above 4 is treated as 4.
- R8: A starting offset of 0 or above is treated as -1.
- R9: Codes are 3-bit two's complement. Slot k occupies codes_o[3k+2:3k], and en_o[k] is the enable of slot k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_start_i | input | 1 | Group-start pulse; configuration is captured at this edge |
| first_ofs_i | input | 3 | Signed offset of the oldest past reference frame |
| ref_cnt_i | input | 3 | Number of reference frames to search |
| codes_o | output | 12 | Four signed slot codes, slot k in bits [3k+2:3k] |
| en_o | output | 4 | Per-slot frame enables |

## Verification
The bench builds the block with its default parameters: four slots, 3-bit codes and a 3-bit count. With these values the whole configuration space of 8 offsets and 8 counts is small enough to sweep completely. The sweep covers every clamped offset, every clamped count and every point where the zero skip falls inside the enabled slots. The bench also checks that the outputs hold while the inputs move between group-start pulses.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_CODE_W = 3;
  localparam int unsigned DEF_CNT_W  = 3;
endpackage

// File: rtl/rfc_cfg_clamp.sv
module rfc_cfg_clamp #(
  parameter int unsigned NUM_SLOTS = rfc_pkg::DEF_SLOTS,
  parameter int unsigned CODE_W    = rfc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W     = rfc_pkg::DEF_CNT_W
) (
  input  logic signed [CODE_W-1:0] ofs_i,
  input  logic        [CNT_W-1:0]  cnt_i,
  output logic signed [CODE_W-1:0] ofs_o,
  output logic        [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = NUM_SLOTS[CNT_W-1:0];
  localparam logic [CNT_W-1:0]  CNT_MIN = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CODE_W-1:0] OFS_DEF = '1;

  always_comb begin
    // offset zero is the current frame, so non-negative offsets fall back to -1
    ofs_o = ofs_i[CODE_W-1] ? ofs_i : OFS_DEF;
    if (cnt_i == '0)          cnt_o = CNT_MIN;
    else if (cnt_i > CNT_MAX) cnt_o = CNT_MAX;
    else                      cnt_o = cnt_i;
  end
endmodule

// File: rtl/rfc_cfg_reg.sv
module rfc_cfg_reg #(
  parameter int unsigned CODE_W = rfc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W  = rfc_pkg::DEF_CNT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic signed [CODE_W-1:0] ofs_i,
  input  logic        [CNT_W-1:0]  cnt_i,
  output logic signed [CODE_W-1:0] ofs_o,
  output logic        [CNT_W-1:0]  cnt_o
);
  // count resets to zero: no slot enabled until the first group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o <= '1;
      cnt_o <= '0;
    end else if (load_i) begin
      ofs_o <= ofs_i;
      cnt_o <= cnt_i;
    end
  end
endmodule

// File: rtl/rfc_slot_code.sv
module rfc_slot_code #(
  parameter int unsigned CODE_W = rfc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W  = rfc_pkg::DEF_CNT_W,
  parameter int unsigned IDX    = 0
) (
  input  logic signed [CODE_W-1:0] ofs_i,
  input  logic        [CNT_W-1:0]  cnt_i,
  output logic        [CODE_W-1:0] code_o,
  output logic                     en_o
);
  localparam logic [CODE_W:0]  STEP  = IDX[CODE_W:0];
  localparam logic [CODE_W:0]  ONE   = {{CODE_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] IDX_C = IDX[CNT_W-1:0];

  logic [CODE_W:0] base, sum, adj;

  always_comb begin
    base = {ofs_i[CODE_W-1], ofs_i};
    sum  = base + STEP;
    adj  = sum[CODE_W] ? sum : sum + ONE;  // step past zero
    en_o   = cnt_i > IDX_C;
    code_o = en_o ? adj[CODE_W-1:0] : '0;
  end
endmodule

// File: rtl/rfc_code_gen.sv
module rfc_code_gen #(
  parameter int unsigned NUM_SLOTS = rfc_pkg::DEF_SLOTS,
  parameter int unsigned CODE_W    = rfc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W     = rfc_pkg::DEF_CNT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        grp_start_i,
  input  logic [CODE_W-1:0]           first_ofs_i,
  input  logic [CNT_W-1:0]            ref_cnt_i,
  output logic [NUM_SLOTS*CODE_W-1:0] codes_o,
  output logic [NUM_SLOTS-1:0]        en_o
);
  logic signed [CODE_W-1:0] ofs_cl, ofs_q;
  logic        [CNT_W-1:0]  cnt_cl, cnt_q;

  rfc_cfg_clamp #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_clamp (
    .ofs_i (first_ofs_i),
    .cnt_i (ref_cnt_i),
    .ofs_o (ofs_cl),
    .cnt_o (cnt_cl)
  );

  rfc_cfg_reg #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (grp_start_i),
    .ofs_i  (ofs_cl),
    .cnt_i  (cnt_cl),
    .ofs_o  (ofs_q),
    .cnt_o  (cnt_q)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    rfc_slot_code #(.CODE_W(CODE_W), .CNT_W(CNT_W), .IDX(k)) u_slot (
      .ofs_i  (ofs_q),
      .cnt_i  (cnt_q),
      .code_o (codes_o[k*CODE_W +: CODE_W]),
      .en_o   (en_o[k])
    );
  end
endmodule

// File: rtl/rfc_code_gen_chk.sv
module rfc_code_gen_chk #(
  parameter int unsigned NUM_SLOTS = rfc_pkg::DEF_SLOTS,
  parameter int unsigned CODE_W    = rfc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W     = rfc_pkg::DEF_CNT_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        grp_start_i,
  input logic [CODE_W-1:0]           first_ofs_i,
  input logic [CNT_W-1:0]            ref_cnt_i,
  input logic [NUM_SLOTS*CODE_W-1:0] codes_o,
  input logic [NUM_SLOTS-1:0]        en_o
);
  localparam logic [NUM_SLOTS-1:0] EN_ONE  = {{(NUM_SLOTS-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]     CNT_MAX = NUM_SLOTS[CNT_W-1:0];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_start_i |=> ($stable(codes_o) && $stable(en_o)));

  p_first_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_start_i |=> en_o[0]);

  p_contig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & (en_o + EN_ONE)) == '0));

  p_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_start_i && ref_cnt_i != '0 && ref_cnt_i <= CNT_MAX)
      |=> ($countones(en_o) == int'($past(ref_cnt_i))));

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_start_i && first_ofs_i[CODE_W-1])
      |=> (codes_o[CODE_W-1:0] == $past(first_ofs_i)));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
    p_unused_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_o[k] |-> (codes_o[k*CODE_W +: CODE_W] == '0));
    p_used_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[k] |-> (codes_o[k*CODE_W +: CODE_W] != '0));
    if (k + 1 < NUM_SLOTS) begin : g_ord
      p_rising_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o[k+1] |-> ($signed(codes_o[(k+1)*CODE_W +: CODE_W]) >
                       $signed(codes_o[k*CODE_W +: CODE_W])));
    end
  end
endmodule

bind rfc_code_gen rfc_code_gen_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grp_start_i (grp_start_i),
  .first_ofs_i (first_ofs_i),
  .ref_cnt_i   (ref_cnt_i),
  .codes_o     (codes_o),
  .en_o        (en_o)
);

// File: tb/rfc_code_gen_bench.sv
`timescale 1ns/1ps
module rfc_code_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        grp_start_i = 1'b0;
  logic [2:0]  first_ofs_i = '0;
  logic [2:0]  ref_cnt_i = '0;
  logic [11:0] codes_o;
  logic [3:0]  en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rfc_code_gen u_rfc_code_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .grp_start_i(grp_start_i),
    .first_ofs_i(first_ofs_i), .ref_cnt_i(ref_cnt_i),
    .codes_o(codes_o), .en_o(en_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cfg(input int ofs, input int cnt,
                            output logic [11:0] ec, output logic [3:0] ee);
    int s, n, v;
    s = (ofs >= 0) ? -1 : ofs;
    n = (cnt == 0) ? 1 : ((cnt > 4) ? 4 : cnt);
    ec = '0; ee = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < n) begin
        v = s + k;
        if (v >= 0) v = v + 1;
        ec[k*3 +: 3] = v[2:0];
        ee[k] = 1'b1;
      end
    end
  endtask

  task automatic apply(input int ofs, input int cnt);
    @(negedge clk_i);
    first_ofs_i = ofs[2:0];
    ref_cnt_i   = cnt[2:0];
    grp_start_i = 1'b1;
    @(negedge clk_i);
    grp_start_i = 1'b0;
  endtask

  initial begin
    logic [11:0] ec;
    logic [3:0]  ee;
    string tag;
    repeat (3) @(negedge clk_i);
    chk(codes_o == '0 && en_o == '0, "R1 in reset", {16'h0, en_o, codes_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(codes_o == '0 && en_o == '0, "R1 after reset", {16'h0, en_o, codes_o}, 32'h0);
    // inputs move without a pulse: no effect
    first_ofs_i = 3'b101; ref_cnt_i = 3'd4;
    repeat (3) @(negedge clk_i);
    chk(codes_o == '0 && en_o == '0, "R2 ignored before pulse", {16'h0, en_o, codes_o}, 32'h0);

    for (int o = -4; o <= 3; o++) begin
      for (int c = 0; c <= 7; c++) begin
        apply(o, c);
        expect_cfg(o, c, ec, ee);
        if (o >= 0)              tag = "R8 offset clamp";
        else if (c == 0 || c > 4) tag = "R7 count clamp";
        else                     tag = "R4 code sequence";
        chk(codes_o == ec, tag, {20'h0, codes_o}, {20'h0, ec});
        chk(en_o == ee, "R5 enables", {28'h0, en_o}, {28'h0, ee});
        for (int k = 0; k < 4; k++)
          if (!ee[k]) chk(codes_o[k*3 +: 3] == 3'b000 && !en_o[k], "R6 unused slot",
                          {28'h0, en_o[k], codes_o[k*3 +: 3]}, 32'h0);
        if (o < 0)
          chk($signed(codes_o[2:0]) == o, "R3 first code", {29'h0, codes_o[2:0]}, o);
      end
    end

    apply(-3, 4);
    chk(codes_o == 12'b001_111_110_101 && en_o == 4'b1111, "R9 packing -3..+1",
        {16'h0, en_o, codes_o}, {16'h0, 4'b1111, 12'b001_111_110_101});
    first_ofs_i = 3'b111; ref_cnt_i = 3'd1;
    repeat (4) @(negedge clk_i);
    chk(codes_o == 12'b001_111_110_101 && en_o == 4'b1111, "R2 hold during group",
        {16'h0, en_o, codes_o}, {16'h0, 4'b1111, 12'b001_111_110_101});
    apply(-2, 4);
    chk(codes_o == 12'b010_001_111_110 && en_o == 4'b1111, "R4 two past two future",
        {16'h0, en_o, codes_o}, {16'h0, 4'b1111, 12'b010_001_111_110});
    apply(-4, 2);
    chk(codes_o == 12'b000_000_101_100 && en_o == 4'b0011, "R6 two slots unused",
        {16'h0, en_o, codes_o}, {16'h0, 4'b0011, 12'b000_000_101_100});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule